// File: doc/BRIEF.md
# Parallel EEPROM Bus Timing Controller

This block sits on the host side of an asynchronous, byte-wide parallel EEPROM. It drives the chip-enable, output-enable and write-enable strobes, the address lines, and a data bus split into output, output-enable and input. It takes one read or one write at a time from a valid/ready command port. A read returns its byte together with a one-cycle response pulse.

Every strobe phase lasts a whole number of system clock cycles. Each count is worked out at elaboration from a nanosecond figure and the clock period given as parameters. The figure is rounded up, and no phase is shorter than one cycle.

After a write releases the bus, the controller holds off all traffic for the device's internal programming time. After reset it refuses every command for a power-up inhibit window. A read is followed by a float interval, so the device's output buffers have turned off before the controller may drive the bus again.

Top module: `eeprom_bus_ctrl`

## Requirements
- R1: After reset is released, `cmd_ready` stays low for exactly INIT = ceil(T_INIT_NS / CLK_PERIOD_NS) cycles (at least 1). During this window all three strobes are high and `mem_dq_oe` is low.
- R2: An accepted read holds `mem_ce_n` and `mem_oe_n` low together for exactly RD = max(ceil(T_ACC_NS/P), ceil(T_OE_NS/P)) cycles, with each count at least 1. `rsp_rdata` then carries the value on `mem_dq_i` in the last of those cycles.
- R3: After the read strobes rise, `cmd_ready` stays low for exactly FLT = ceil(T_FLOAT_NS/P) cycles (at least 1). During this time the strobes stay high and the data bus is not driven.
- R4: An accepted write holds `mem_we_n` low for exactly WL = max(ceil(T_WP_NS/P), ceil(T_DS_NS/P)) cycles. Throughout that time `mem_ce_n` is low, `mem_oe_n` is high, `mem_dq_oe` is high and `mem_dq_o` equals the command's write byte.
- R5: After `mem_we_n` rises, `mem_ce_n` stays low and the write byte stays driven for exactly WH = ceil(T_DH_NS/P) cycles (at least 1). After that the bus is released.
- R6: After the bus is released following a write, `cmd_ready` stays low and `mem_ce_n` stays high for exactly PROG = ceil(T_PROG_NS/P) cycles.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. `mem_oe_n` is always high while `mem_we_n` is low.
- R8: From the cycle after acceptance until the access ends, `mem_addr` equals the address of the accepted command.
- R9: A command presented while `cmd_ready` is low is ignored. It produces no strobe and no response, and it leaves the device contents unchanged.
- R10: `rsp_valid` is high for exactly one cycle, only after a read, and only in the first cycle after `mem_oe_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_addr | output | ADDR_W | Device address lines |
| mem_dq_o | output | DATA_W | Data to the device |
| mem_dq_oe | output | 1 | Host drives the data lines |
| mem_dq_i | input | DATA_W | Data from the device |

## Verification
The bench writes to every location of a sixteen-entry model except one, then reads all sixteen back. Each write uses a distinct byte derived from its address, and high address bits are set. This separates correct address and data routing from swapped or stuck lines, and every single phase is measured against its arithmetically derived cycle count. One location is never written by a valid command, and a write aimed at it is presented during a programming wait. Reading it back shows whether an ignored command leaked through to the device. The length of the read strobe is also checked against the returned data, which tells early sampling apart from a correct capture.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_RD_FLT,
      ST_WR_LOW,
      ST_WR_HOLD,
      ST_PROG
   } ebc_state_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ebc_phase_timer.sv
module ebc_phase_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          last
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/ebc_inhibit.sv
module ebc_inhibit #(
   parameter int unsigned INIT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic active
);
   localparam int unsigned IW = ebc_pkg::bits_for(INIT_CYC);

   logic [IW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= IW'(INIT_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl #(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_ACC_NS      = 200,
   parameter int unsigned T_OE_NS       = 80,
   parameter int unsigned T_FLOAT_NS    = 50,
   parameter int unsigned T_WP_NS       = 100,
   parameter int unsigned T_DS_NS       = 50,
   parameter int unsigned T_DH_NS       = 10,
   parameter int unsigned T_AH_NS       = 75,
   parameter int unsigned T_PROG_NS     = 10_000_000,
   parameter int unsigned T_INIT_NS     = 10_000_000,
   parameter bit          RDATA_HOLD    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_we,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   import ebc_pkg::*;

   localparam int unsigned P        = CLK_PERIOD_NS;
   localparam int unsigned RD_CYC   = max2(ns_to_cyc(T_ACC_NS, P), ns_to_cyc(T_OE_NS, P));
   localparam int unsigned FLT_CYC  = ns_to_cyc(T_FLOAT_NS, P);
   localparam int unsigned WL_CYC   = max2(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_DS_NS, P));
   localparam int unsigned WH_CYC   = ns_to_cyc(T_DH_NS, P);
   localparam int unsigned AH_CYC   = ns_to_cyc(T_AH_NS, P);
   localparam int unsigned PROG_CYC = ns_to_cyc(T_PROG_NS, P);
   localparam int unsigned INIT_CYC = ns_to_cyc(T_INIT_NS, P);
   localparam int unsigned MAX_CYC  = max2(max2(max2(RD_CYC, FLT_CYC), max2(WL_CYC, WH_CYC)), PROG_CYC);
   localparam int unsigned TW       = bits_for(MAX_CYC);

   // elaboration-time parameter checks
   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("eeprom_bus_ctrl: CLK_PERIOD_NS must be nonzero");
   end
   if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
      $error("eeprom_bus_ctrl: ADDR_W and DATA_W must be nonzero");
   end
   if (AH_CYC > WL_CYC + WH_CYC + PROG_CYC) begin : g_bad_hold
      $error("eeprom_bus_ctrl: address hold exceeds the write access");
   end

   ebc_state_e    state_q, state_d;
   logic          tmr_load, tmr_last, inhibit;
   logic [TW-1:0] tmr_val;
   logic          accept;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic          rsp_valid_q;

   ebc_phase_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   ebc_inhibit #(.INIT_CYC(INIT_CYC)) u_inhibit (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (inhibit)
   );

   assign cmd_ready = (state_q == ST_IDLE) && !inhibit;
   assign accept    = cmd_valid && cmd_ready;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               if (cmd_we) begin
                  state_d = ST_WR_LOW;
                  tmr_val = TW'(WL_CYC - 1);
               end else begin
                  state_d = ST_RD;
                  tmr_val = TW'(RD_CYC - 1);
               end
            end
         end
         ST_RD: begin
            if (tmr_last) begin
               state_d  = ST_RD_FLT;
               tmr_load = 1'b1;
               tmr_val  = TW'(FLT_CYC - 1);
            end
         end
         ST_RD_FLT: begin
            if (tmr_last) state_d = ST_IDLE;
         end
         ST_WR_LOW: begin
            if (tmr_last) begin
               state_d  = ST_WR_HOLD;
               tmr_load = 1'b1;
               tmr_val  = TW'(WH_CYC - 1);
            end
         end
         ST_WR_HOLD: begin
            if (tmr_last) begin
               state_d  = ST_PROG;
               tmr_load = 1'b1;
               tmr_val  = TW'(PROG_CYC - 1);
            end
         end
         ST_PROG: begin
            if (tmr_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         wdata_q     <= '0;
         rsp_valid_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= (state_q == ST_RD) && tmr_last;
         if (accept) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
         end
      end
   end

   // read data capture: holding or zeroed outside the response pulse
   if (RDATA_HOLD) begin : g_rdata_hold
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                rdata_q <= '0;
         else if ((state_q == ST_RD) && tmr_last)   rdata_q <= mem_dq_i;
      end
      assign rsp_rdata = rdata_q;
   end else begin : g_rdata_gate
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                rdata_q <= '0;
         else if ((state_q == ST_RD) && tmr_last)   rdata_q <= mem_dq_i;
         else                                       rdata_q <= '0;
      end
      assign rsp_rdata = rdata_q;
   end

   assign rsp_valid = rsp_valid_q;
   assign mem_ce_n  = !((state_q == ST_RD) || (state_q == ST_WR_LOW) || (state_q == ST_WR_HOLD));
   assign mem_oe_n  = (state_q != ST_RD);
   assign mem_we_n  = (state_q != ST_WR_LOW);
   assign mem_dq_oe = (state_q == ST_WR_LOW) || (state_q == ST_WR_HOLD);
   assign mem_dq_o  = wdata_q;
   assign mem_addr  = addr_q;

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);
   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n)); // R7
   AST_OE_HIGH_WHILE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n); // R7
   AST_WE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && !mem_ce_n)); // R4
   AST_DRIVE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_ce_n); // R5
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(!mem_oe_n)); // R10
   AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (mem_ce_n && !mem_dq_oe)); // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
endmodule

bind eeprom_bus_ctrl ebc_checker #(.ADDR_W(ADDR_W)) u_ebc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rsp_valid (rsp_valid),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/tb_eeprom_bus_ctrl.sv
module tb_eeprom_bus_ctrl;
   localparam int CLK_NS  = 10;
   localparam int AW      = 15;
   localparam int DW      = 8;
   localparam int PROG_NS = 300;
   localparam int INIT_NS = 200;
   localparam int GUARD   = 5000;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + CLK_NS - 1) / CLK_NS;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int RD_E   = (cdiv(200) > cdiv(80)) ? cdiv(200) : cdiv(80);
   localparam int FLT_E  = cdiv(50);
   localparam int WL_E   = (cdiv(100) > cdiv(50)) ? cdiv(100) : cdiv(50);
   localparam int WH_E   = cdiv(10);
   localparam int PROG_E = cdiv(PROG_NS);
   localparam int INIT_E = cdiv(INIT_NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic          cmd_we = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   logic [DW-1:0] dev_mem [16];
   logic [DW-1:0] exp_mem [16];
   int            checks = 0;
   int            errors = 0;
   bit            finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   eeprom_bus_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS),
      .T_PROG_NS(PROG_NS), .T_INIT_NS(INIT_NS)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   // device model: drives data only while both enables are low
   assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? dev_mem[mem_addr[3:0]] : '0;

   always @(posedge mem_we_n)
      if (!mem_ce_n && mem_dq_oe) dev_mem[mem_addr[3:0]] = mem_dq_o;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ready();
      for (int g = 0; g < GUARD && !cmd_ready; g++) @(negedge clk);
   endtask

   // poke: present an extra write to address 9 during the programming wait
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
      int n, bad, rsp_seen;
      wait_ready();
      cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 0; bad = 0;
      while (!mem_we_n && n < GUARD) begin
         if (mem_ce_n || !mem_oe_n || !mem_dq_oe || mem_dq_o != d) bad++;
         if (mem_addr != a) bad++;
         n++; @(negedge clk);
      end
      chk(n == WL_E, "R4 write-low length", n, WL_E);
      chk(bad == 0, "R4/R8 write-low strobes, data, address", bad, 0);
      n = 0; bad = 0;
      while (mem_dq_oe && n < GUARD) begin
         if (mem_ce_n || mem_dq_o != d || mem_addr != a || !mem_we_n) bad++;
         n++; @(negedge clk);
      end
      chk(n == WH_E, "R5 data hold length", n, WH_E);
      chk(bad == 0, "R5 hold-phase signals", bad, 0);
      n = 0; bad = 0; rsp_seen = 0;
      while (!cmd_ready && n < GUARD) begin
         if (!mem_ce_n || mem_dq_oe) bad++;
         if (rsp_valid) rsp_seen++;
         if (poke && n == 3) begin
            cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = AW'(9); cmd_wdata = 8'h3C;
         end
         if (poke && n == 8) cmd_valid = 1'b0;
         n++; @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(n == PROG_E, "R6 programming wait length", n, PROG_E);
      chk(bad == 0, "R6 bus idle during programming", bad, 0);
      if (poke) chk(bad == 0 && rsp_seen == 0, "R9 ignored command made no access", rsp_seen, 0);
      exp_mem[a[3:0]] = d;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      int n, bad;
      wait_ready();
      cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = a; cmd_wdata = 8'hFF;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 0; bad = 0;
      while (!mem_oe_n && n < GUARD) begin
         if (mem_ce_n || mem_dq_oe || !mem_we_n || mem_addr != a || rsp_valid) bad++;
         n++; @(negedge clk);
      end
      chk(n == RD_E, "R2 read strobe length", n, RD_E);
      chk(bad == 0, "R2/R7/R8 read strobes and address", bad, 0);
      chk(rsp_valid == 1'b1, "R10 response after output-enable rises", int'(rsp_valid), 1);
      chk(rsp_rdata == exp_mem[a[3:0]], "R2 read data", int'(rsp_rdata), int'(exp_mem[a[3:0]]));
      n = 0; bad = 0;
      while (!cmd_ready && n < GUARD) begin
         if (!mem_ce_n || !mem_oe_n || mem_dq_oe) bad++;
         if (n > 0 && rsp_valid) bad++;
         n++; @(negedge clk);
      end
      chk(n == FLT_E, "R3 float wait length", n, FLT_E);
      chk(bad == 0, "R3/R10 float phase quiet and single pulse", bad, 0);
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n, bad;
      for (int i = 0; i < 16; i++) begin
         dev_mem[i] = 8'hA0 ^ 8'(i);
         exp_mem[i] = 8'hA0 ^ 8'(i);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: inhibit window after reset
      n = 0; bad = 0;
      while (!cmd_ready && n < GUARD) begin
         if (!mem_ce_n || !mem_oe_n || !mem_we_n || mem_dq_oe) bad++;
         if (n == 4) cmd_valid = 1'b1;
         n++; @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(n == INIT_E, "R1 power-up inhibit length", n, INIT_E);
      chk(bad == 0, "R1/R9 bus idle during inhibit", bad, 0);

      // write sweep: every location except 9, distinct data, high address bits set
      for (int a = 0; a < 16; a++) begin
         if (a != 9)
            do_write(AW'(a) | AW'(a << 8), DW'(a * 37 + 5), a == 3);
      end
      // read sweep over all locations, including the never-written one
      for (int a = 15; a >= 0; a--) do_read(AW'(a) | AW'((15 - a) << 10));
      chk(exp_mem[9] == (8'hA0 ^ 8'h09), "R9 bench shadow untouched", int'(exp_mem[9]), int'(8'hA9));
      // back-to-back read then write then read of one location
      do_read(AW'(5));
      do_write(AW'(5), 8'h5A, 1'b0);
      do_read(AW'(5));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule